// File: doc/BRIEF.md
# Event-Flag Serial Port

This block is a bus-attached serial port with five 32-bit word registers: a data word, a bit-period divisor, a status word, a control word and a debug word. Software sends a byte by writing the data word. The byte goes out on the transmit line as an 8N1 frame: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A byte received on the receive line is held in the data word until software acknowledges it. There is no FIFO. The port holds at most one received byte and sends at most one byte at a time.

The status word has two sticky event flags, one for a received byte and one for a finished transmission. Software clears them by writing ones to them. The status word also has a transmit-holding-empty bit that always reads as one. A single level interrupt combines each event with its enable bit in the control word.

The register port has no back-pressure. An access presented with `bus_valid` high completes in that cycle. A write takes effect at that clock edge. A read returns data combinationally in the same cycle and has no side effects. Addresses are byte addresses, the word index is `bus_addr >> 2`, and the two low address bits are ignored.

Top module: `uart_evt`

## Requirements
- R1: The divisor (byte offset 0x04), control (0x0C) and debug (0x10) words are plain 32-bit read/write storage and read back what was last written. A read of an undefined word index (5 to 7) returns zero, and a write to one changes nothing. The two low address bits are ignored.
- R2: After reset, the data, divisor, control and debug words read zero, the status word (0x08) reads 0x1, `irq` is low and `txd` is high.
- R3: Status bit 0 (transmit-holding-empty) always reads one, and no write can change it.
- R4: A write to the status word clears status bit 1 (receive event) and/or bit 2 (transmit event) wherever the written bit is one. Bits written as zero are left unchanged.
- R5: `irq` is high exactly when (control bit 0 and status bit 1) or (control bit 1 and status bit 2).
- R6: A write to the data word (0x00) while the transmitter is idle sends the low byte of the write as an 8N1 frame, least significant bit first. Each bit lasts as many clocks as the low 16 bits of the divisor. The transmit event is set when the stop bit ends, not at the moment of the write.
- R7: A write to the data word while a frame is still being sent is ignored: the frame in progress is unchanged and no second frame follows.
- R8: The receiver sees a falling edge on `rxd` and then samples each bit at its midpoint. It stores the received byte in bits 7:0 of the data word (upper bits read zero) and sets the receive event. The byte stays there after the event is cleared.
- R9: A byte that arrives while the receive event is still set is dropped, and the data word keeps the earlier byte.
- R10: A divisor whose low 16 bits are zero acts as a divisor of one, so each bit lasts one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; word index is bits 4:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| irq | output | 1 | Level interrupt |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, idles high |

## Verification
The hardest situations to reach from the ports are the ones where two things overlap in time. One is a second data-word write that lands in the middle of a frame already being sent. The other is a second incoming frame that arrives while the first byte has not yet been acknowledged. The bench places the extra write a known number of clocks after the first, between two mid-bit samples of the transmit line. It then checks every bit of the frame in progress, and checks that the line stays high afterwards. For reception, the bench drives a complete second frame on `rxd` without clearing the event, then reads the data word. It checks the timing of the transmit event with two status reads: one during the stop bit, where the event must still be clear, and one just after the stop bit ends, where it must be set.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int unsigned WIDX_DATA = 0;
  localparam int unsigned WIDX_DIV  = 1;
  localparam int unsigned WIDX_STAT = 2;
  localparam int unsigned WIDX_CTRL = 3;
  localparam int unsigned WIDX_DBG  = 4;

  localparam int unsigned STAT_HOLD_EMPTY = 0;
  localparam int unsigned STAT_RX_EV      = 1;
  localparam int unsigned STAT_TX_EV      = 2;

  localparam int unsigned CTRL_RX_IE = 0;
  localparam int unsigned CTRL_TX_IE = 1;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_START,
    LN_DATA,
    LN_STOP
  } line_state_e;
endpackage

// File: rtl/uart_evt_tx.sv
module uart_evt_tx
  import uart_evt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     bit_len,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] din,
  output logic                 busy,
  output logic                 done,
  output logic                 txd
);
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  line_state_e            state;
  logic [DIV_W-1:0]       cnt;
  logic [BIT_W-1:0]       bitn;
  logic [DATA_BITS-1:0]   shreg;
  logic                   line_q;
  logic                   bit_end;

  assign bit_end = (cnt == bit_len - 1'b1);
  assign busy    = (state != LN_IDLE);
  assign done    = (state == LN_STOP) && bit_end;
  assign txd     = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LN_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      line_q <= 1'b1;
    end else begin
      case (state)
        LN_IDLE: begin
          if (start) begin
            state  <= LN_START;
            cnt    <= '0;
            shreg  <= din;
            line_q <= 1'b0;
          end
        end
        LN_START: begin
          if (bit_end) begin
            state  <= LN_DATA;
            cnt    <= '0;
            bitn   <= '0;
            line_q <= shreg[0];
            shreg  <= shreg >> 1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LN_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (bitn == BIT_W'(DATA_BITS - 1)) begin
              state  <= LN_STOP;
              line_q <= 1'b1;
            end else begin
              bitn   <= bitn + 1'b1;
              line_q <= shreg[0];
              shreg  <= shreg >> 1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            state <= LN_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LN_IDLE) |-> txd);

  assert_done_returns_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == LN_IDLE));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == LN_START && !bit_end) |=> (state == LN_START && $stable(shreg)));
endmodule

// File: rtl/uart_evt_rx.sv
module uart_evt_rx
  import uart_evt_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     bit_len,
  input  logic                 rxd,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_out
);
  localparam int BIT_W = $clog2(DATA_BITS + 1);

  line_state_e          state;
  logic [DIV_W-1:0]     cnt;
  logic [BIT_W-1:0]     bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 sync1, sync2, prev;
  logic                 bit_end, mid_pt;

  assign bit_end    = (cnt == bit_len - 1'b1);
  assign mid_pt     = (cnt == (bit_len >> 1));
  assign byte_valid = (state == LN_STOP) && bit_end;
  assign byte_out   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= rxd;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LN_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else begin
      case (state)
        LN_IDLE: begin
          if (prev && !sync2) begin
            state <= LN_START;
            cnt   <= '0;
          end
        end
        LN_START: begin
          if (mid_pt) begin
            cnt  <= '0;
            bitn <= '0;
            state <= sync2 ? LN_IDLE : LN_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LN_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= {sync2, shreg[DATA_BITS-1:1]};
            if (bitn == BIT_W'(DATA_BITS - 1)) state <= LN_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            state <= LN_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assert_valid_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> (state == LN_IDLE));

  assert_byte_stable_in_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LN_STOP && $past(state) == LN_STOP) |-> $stable(shreg));
endmodule

// File: rtl/uart_evt.sv
module uart_evt
  import uart_evt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REG_W     = 32,
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              txd,
  input  logic              rxd
);
  localparam int IDX_W = ADDR_W - 2;

  logic [REG_W-1:0]     div_q, ctrl_q, dbg_q;
  logic [DATA_BITS-1:0] rx_byte_q;
  logic                 rx_evt_q, tx_evt_q;
  logic [IDX_W-1:0]     widx;
  logic                 wr_en, wr_data, wr_stat;
  logic                 clr_rx, clr_tx;
  logic [DIV_W-1:0]     bit_len;
  logic                 tx_busy, tx_done;
  logic                 rx_valid;
  logic [DATA_BITS-1:0] rx_byte;
  logic [REG_W-1:0]     stat_word;
  logic                 unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_en   = bus_valid && bus_we;
  assign wr_data = wr_en && (widx == IDX_W'(WIDX_DATA));
  assign wr_stat = wr_en && (widx == IDX_W'(WIDX_STAT));
  assign clr_rx  = wr_stat && bus_wdata[STAT_RX_EV];
  assign clr_tx  = wr_stat && bus_wdata[STAT_TX_EV];
  assign bit_len = (div_q[DIV_W-1:0] == '0) ? DIV_W'(1) : div_q[DIV_W-1:0];

  uart_evt_tx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_len (bit_len),
    .start   (wr_data),
    .din     (bus_wdata[DATA_BITS-1:0]),
    .busy    (tx_busy),
    .done    (tx_done),
    .txd     (txd)
  );

  uart_evt_rx #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_len    (bit_len),
    .rxd        (rxd),
    .byte_valid (rx_valid),
    .byte_out   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dbg_q  <= '0;
    end else if (wr_en) begin
      if (widx == IDX_W'(WIDX_DIV))  div_q  <= bus_wdata;
      if (widx == IDX_W'(WIDX_CTRL)) ctrl_q <= bus_wdata;
      if (widx == IDX_W'(WIDX_DBG))  dbg_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_evt_q  <= 1'b0;
      rx_byte_q <= '0;
    end else if (rx_valid && !rx_evt_q) begin
      rx_evt_q  <= 1'b1;
      rx_byte_q <= rx_byte;
    end else if (clr_rx) begin
      rx_evt_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_evt_q <= 1'b0;
    else if (tx_done) tx_evt_q <= 1'b1;
    else if (clr_tx)  tx_evt_q <= 1'b0;
  end

  always_comb begin
    stat_word = '0;
    stat_word[STAT_HOLD_EMPTY] = 1'b1;
    stat_word[STAT_RX_EV]      = rx_evt_q;
    stat_word[STAT_TX_EV]      = tx_evt_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_we) begin
      case (widx)
        IDX_W'(WIDX_DATA): bus_rdata = REG_W'(rx_byte_q);
        IDX_W'(WIDX_DIV):  bus_rdata = div_q;
        IDX_W'(WIDX_STAT): bus_rdata = stat_word;
        IDX_W'(WIDX_CTRL): bus_rdata = ctrl_q;
        IDX_W'(WIDX_DBG):  bus_rdata = dbg_q;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign irq = (ctrl_q[CTRL_RX_IE] && rx_evt_q) || (ctrl_q[CTRL_TX_IE] && tx_evt_q);

  assert_txevt_from_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_evt_q) |-> $past(tx_done));

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt_q && !clr_rx) |=> $stable(rx_byte_q));

  assert_irq_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_evt_q || tx_evt_q));

  assert_tx_busy_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> tx_busy);
endmodule

// File: tb/uart_evt_test.sv
`timescale 1ns/1ps
module uart_evt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, txd;
  logic        rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_evt uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .txd(txd), .rxd(rxd)
  );

  localparam int NVEC = 14;
  localparam logic [69:0] VEC [NVEC] = '{
    {1'b1, 5'h04, 32'hDEADBEEF, 32'h0},
    {1'b0, 5'h04, 32'h0,        32'hDEADBEEF},
    {1'b1, 5'h0C, 32'hFFFFFFF8, 32'h0},
    {1'b0, 5'h0C, 32'h0,        32'hFFFFFFF8},
    {1'b0, 5'h0E, 32'h0,        32'hFFFFFFF8},
    {1'b1, 5'h10, 32'h12345679, 32'h0},
    {1'b0, 5'h10, 32'h0,        32'h12345679},
    {1'b1, 5'h08, 32'hFFFFFFFF, 32'h0},
    {1'b0, 5'h08, 32'h0,        32'h00000001},
    {1'b0, 5'h14, 32'h0,        32'h0},
    {1'b1, 5'h1C, 32'hA5A5A5A5, 32'h0},
    {1'b0, 5'h1C, 32'h0,        32'h0},
    {1'b0, 5'h00, 32'h0,        32'h0},
    {1'b1, 5'h0C, 32'h00000000, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input int div);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rxd = fr[i];
      repeat (div - 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic tx_capture(input string tag, input logic [7:0] exp, input bit inject);
    logic [31:0] st;
    repeat (3) @(negedge clk);
    chk({tag, " start"}, {31'b0, txd}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      if (i == 0 && inject) begin
        bus_write(5'h00, 32'h000000FF);
        repeat (6) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      chk($sformatf("%s bit%0d", tag, i), {31'b0, txd}, {31'b0, exp[i]});
    end
    repeat (8) @(negedge clk);
    chk({tag, " stop"}, {31'b0, txd}, 32'h1);
    bus_read(5'h08, st);
    chk({tag, " no tx event during stop bit"}, st & 32'h4, 32'h0);
    repeat (5) @(negedge clk);
    bus_read(5'h08, st);
    chk({tag, " tx event after stop bit"}, st & 32'h4, 32'h4);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    bus_read(5'h00, rd); chk("R2 data reset", rd, 32'h0);
    bus_read(5'h04, rd); chk("R2 div reset", rd, 32'h0);
    bus_read(5'h08, rd); chk("R2 stat reset", rd, 32'h1);
    bus_read(5'h0C, rd); chk("R2 ctrl reset", rd, 32'h0);
    bus_read(5'h10, rd); chk("R2 dbg reset", rd, 32'h0);
    chk("R2 irq reset", {31'b0, irq}, 32'h0);
    chk("R2 txd reset", {31'b0, txd}, 32'h1);

    // R1 / R3 vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][69]) bus_write(VEC[i][68:64], VEC[i][63:32]);
      else begin
        bus_read(VEC[i][68:64], rd);
        chk($sformatf("R1 R3 vector %0d", i), rd, VEC[i][31:0]);
      end
    end
    chk("R3 irq after table", {31'b0, irq}, 32'h0);

    // R10 divisor zero acts as one
    bus_write(5'h04, 32'hFFFF0000);
    bus_write(5'h00, 32'h000000A5);
    chk("R10 start", {31'b0, txd}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk($sformatf("R10 bit%0d", i), {31'b0, txd}, {31'b0, 1'(8'hA5 >> i)});
    end
    @(negedge clk);
    chk("R10 stop", {31'b0, txd}, 32'h1);
    @(negedge clk);
    bus_read(5'h08, rd); chk("R10 tx event", rd, 32'h5);
    bus_write(5'h08, 32'h4);

    // R6 transmission at divisor 8
    bus_write(5'h04, 32'h8);
    bus_write(5'h00, 32'hFFFFFF3C);
    tx_capture("R6", 8'h3C, 1'b0);

    // R5 transmit interrupt
    chk("R5 irq tx disabled", {31'b0, irq}, 32'h0);
    bus_write(5'h0C, 32'h2);
    chk("R5 irq tx enabled", {31'b0, irq}, 32'h1);
    bus_write(5'h08, 32'h4);
    bus_read(5'h08, rd); chk("R4 tx event cleared", rd, 32'h1);
    chk("R5 irq after clear", {31'b0, irq}, 32'h0);

    // R7 write while busy ignored
    bus_write(5'h00, 32'h000000C6);
    tx_capture("R7", 8'hC6, 1'b1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) chk("R7 no second frame", {31'b0, txd}, 32'h1);
    end
    chk("R7 line idle", {31'b0, txd}, 32'h1);

    // R8 reception
    bus_write(5'h0C, 32'h0);
    send_rx(8'h5A, 8);
    bus_read(5'h00, rd); chk("R8 rx data", rd, 32'h5A);
    bus_read(5'h08, rd); chk("R8 R4 rx and tx events", rd, 32'h7);
    chk("R5 irq no enables", {31'b0, irq}, 32'h0);
    bus_write(5'h0C, 32'h1);
    chk("R5 irq rx enabled", {31'b0, irq}, 32'h1);

    // R4 selective clear: clear rx only
    bus_write(5'h08, 32'h2);
    bus_read(5'h08, rd); chk("R4 only rx cleared", rd, 32'h5);
    chk("R5 irq rx cleared", {31'b0, irq}, 32'h0);
    bus_read(5'h00, rd); chk("R8 data kept after clear", rd, 32'h5A);

    // R9 drop while pending
    send_rx(8'hC3, 8);
    bus_read(5'h00, rd); chk("R9 first byte", rd, 32'hC3);
    send_rx(8'h81, 8);
    bus_read(5'h00, rd); chk("R9 pending byte kept", rd, 32'hC3);
    bus_write(5'h08, 32'h6);
    bus_read(5'h08, rd); chk("R4 both cleared", rd, 32'h1);
    send_rx(8'h81, 8);
    bus_read(5'h00, rd); chk("R8 new byte after ack", rd, 32'h81);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule